// File: doc/BRIEF.md
# Synchronized Four-Channel DAC Update Front End

This block sits between a 16-bit register port and an external serial four-channel DAC. Software places a 12-bit code for each channel into a staging register. Nothing reaches the converter until a write sets the top bit of any channel register. That write starts one burst that carries all four staged codes out over a three-wire serial link: clock, data and an active-low frame select. After the burst, a load strobe makes every analog output move at the same instant.

While the burst runs, the top bit of every channel register reads back as 1, and the `busy` pin is high. The block ignores every register write during that time, so the codes being sent cannot change part-way through. With a 50 MHz core clock the serial clock runs at 25 MHz. A full update, from the triggering write to the fall of `busy`, takes 134 core cycles, which is about 2.7 µs.

Top module: `dac_sync_front`

## Requirements
- R1: During and after a synchronous active-high reset, `dac_cs_n` is 1, `dac_sclk`, `dac_din`, `dac_load` and `busy` are 0, `rd_data` is 0 and all four staged codes are 0.
- R2: A write to address 0xA0 + 2·i (i = 0..3) with bit 15 clear stores bits 11:0 as the staged code of channel i. It starts no transfer: `dac_cs_n` stays 1 and `busy` stays 0.
- R3: `rd_data` is registered and reflects the address one cycle earlier. For a channel address, bits 11:0 are the staged code, bit 15 is the busy state and bits 14:12 are 0. Any other address reads 0.
- R4: A write with bit 15 set to any channel address stores that channel's code and starts a transfer of all four channels. `busy` is 1 from the cycle after that write.
- R5: Each channel is sent as a 16-bit frame, MSB first. Bits 15:14 hold the channel index, bits 13:12 are 0 and bits 11:0 hold the staged code. Frames go out in the order channel 0, 1, 2, 3.
- R6: The first frame begins one cycle after the triggering write. Within a frame, `dac_cs_n` is 0 for 32 cycles. `dac_sclk` is 0 for one cycle and then 1 for one cycle per bit, and `dac_din` changes only when `dac_sclk` falls. `dac_cs_n` is 1 for one cycle between frames. `dac_din` is 0 whenever `dac_cs_n` is 1.
- R7: `dac_load` is 1 for exactly one cycle. That cycle comes one cycle after `dac_cs_n` rises at the end of the last frame. `busy` falls in the following cycle, so it is high for 134 cycles per update.
- R8: Any write made while `busy` is 1 has no effect, whether it is a plain store or a trigger.
- R9: Writes to addresses that are not channel addresses have no effect, and this includes the odd addresses in between.
- R10: A trigger sends all four frames even when no staged code has changed since the previous update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 8 | Register address, used for both write and read |
| wr_data | input | 16 | Write data; bit 15 is the update trigger, bits 11:0 are the code |
| rd_data | output | 16 | Registered read data for the previous cycle's address |
| dac_sclk | output | 1 | Serial clock to the DAC |
| dac_din | output | 1 | Serial data to the DAC, valid on the rising edge of `dac_sclk` |
| dac_cs_n | output | 1 | Active-low frame select |
| dac_load | output | 1 | One-cycle strobe that latches all channels together |
| busy | output | 1 | High while an update is in progress |

## Verification
The bench counts results from the triggering write edge. `busy` and the read-back bit 15 change at that same edge, and the first frame bit appears one edge later. Each later bit slot lasts two cycles and each frame occupies 33 cycles. The load strobe follows 133 edges after the trigger, and `busy` clears at the edge after the strobe. A behavioural model keeps a single offset counter from the trigger and derives every expected pin value from that offset. The bench compares all outputs at each falling clock edge, after the rising edge has settled. Read data is modelled as the value that existed before the sampling edge, because the port holds it for one cycle.

// File: rtl/dac_sync_pkg.sv
package dac_sync_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2,
    ENG_LOAD  = 2'd3
  } eng_state_t;

endpackage

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NCH       = 4,
  parameter int unsigned BASE_ADDR = 'hA0,
  parameter int unsigned STRIDE    = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NCH-1:0]    hit
);

  // one comparator per channel slot
  for (genvar i = 0; i < NCH; i++) begin : g_slot
    localparam logic [ADDR_W-1:0] SLOT_ADDR = ADDR_W'(BASE_ADDR + i * STRIDE);
    assign hit[i] = (addr == SLOT_ADDR);
  end

endmodule

// File: rtl/dac_stage_regs.sv
module dac_stage_regs #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [DATA_W-1:0]            wr_data,
  input  logic [NCH-1:0]               hit,
  input  logic                         eng_done,
  output logic [NCH-1:0][CODE_W-1:0]   codes,
  output logic                         busy_q,
  output logic                         start_q,
  output logic [DATA_W-1:0]            rd_data
);

  localparam int unsigned PAD_W = DATA_W - 1 - CODE_W;

  logic              accept;
  logic [DATA_W-1:0] rd_next;

  // the whole register port is frozen while an update runs
  assign accept = wr_en && !busy_q && (|hit);

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NCH; i++) begin
      if (hit[i]) rd_next = {busy_q, {PAD_W{1'b0}}, codes[i]};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      codes   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      rd_data <= '0;
    end else begin
      start_q <= 1'b0;
      rd_data <= rd_next;
      if (eng_done) busy_q <= 1'b0;
      if (accept) begin
        for (int i = 0; i < NCH; i++) begin
          if (hit[i]) codes[i] <= wr_data[CODE_W-1:0];
        end
        if (wr_data[DATA_W-1]) begin
          busy_q  <= 1'b1;
          start_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dac_serial_engine.sv
module dac_serial_engine
  import dac_sync_pkg::*;
#(
  parameter int unsigned NCH      = 4,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned FRAME_W  = 16,
  parameter int unsigned HALF_DIV = 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [NCH-1:0][CODE_W-1:0] codes,
  output logic                       sclk,
  output logic                       din,
  output logic                       cs_n,
  output logic                       load,
  output logic                       done
);

  localparam int unsigned CH_W   = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned RSV_W  = FRAME_W - CH_W - CODE_W;
  localparam int unsigned BIT_W  = $clog2(FRAME_W);
  localparam int unsigned HCNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [HCNT_W-1:0] HCNT_MAX = HCNT_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0]  BIT_TOP  = BIT_W'(FRAME_W - 1);
  localparam logic [CH_W-1:0]   CH_LAST  = CH_W'(NCH - 1);

  eng_state_t          state;
  logic [CH_W-1:0]     chan_q;
  logic [CH_W-1:0]     chan_nx;
  logic [BIT_W-1:0]    bit_q;
  logic [HCNT_W-1:0]   hcnt;
  logic [FRAME_W-1:0]  shreg;
  logic [FRAME_W-1:0]  frame_first;
  logic [FRAME_W-1:0]  frame_next;

  assign chan_nx     = chan_q + 1'b1;
  assign frame_first = {CH_W'(0), {RSV_W{1'b0}}, codes[0]};
  assign frame_next  = {chan_nx, {RSV_W{1'b0}}, codes[chan_nx]};
  assign done        = (state == ENG_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ENG_IDLE;
      chan_q <= '0;
      bit_q  <= '0;
      hcnt   <= '0;
      shreg  <= '0;
      sclk   <= 1'b0;
      din    <= 1'b0;
      cs_n   <= 1'b1;
      load   <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (start) begin
            chan_q <= '0;
            bit_q  <= BIT_TOP;
            hcnt   <= '0;
            shreg  <= frame_first;
            din    <= frame_first[FRAME_W-1];
            cs_n   <= 1'b0;
            sclk   <= 1'b0;
            state  <= ENG_SHIFT;
          end
        end
        ENG_SHIFT: begin
          if (hcnt == HCNT_MAX) begin
            hcnt <= '0;
            if (!sclk) begin
              sclk <= 1'b1;
            end else begin
              sclk <= 1'b0;
              if (bit_q == '0) begin
                cs_n  <= 1'b1;
                din   <= 1'b0;
                state <= ENG_GAP;
              end else begin
                bit_q <= bit_q - 1'b1;
                shreg <= shreg << 1;
                din   <= shreg[FRAME_W-2];
              end
            end
          end else begin
            hcnt <= hcnt + 1'b1;
          end
        end
        ENG_GAP: begin
          if (chan_q == CH_LAST) begin
            load  <= 1'b1;
            state <= ENG_LOAD;
          end else begin
            chan_q <= chan_nx;
            bit_q  <= BIT_TOP;
            hcnt   <= '0;
            shreg  <= frame_next;
            din    <= frame_next[FRAME_W-1];
            cs_n   <= 1'b0;
            state  <= ENG_SHIFT;
          end
        end
        ENG_LOAD: begin
          load  <= 1'b0;
          state <= ENG_IDLE;
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dac_sync_front.sv
module dac_sync_front #(
  parameter int unsigned NCH       = 4,
  parameter int unsigned CODE_W    = 12,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BASE_ADDR = 'hA0,
  parameter int unsigned STRIDE    = 2,
  parameter int unsigned FRAME_W   = 16,
  parameter int unsigned HALF_DIV  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              dac_sclk,
  output logic              dac_din,
  output logic              dac_cs_n,
  output logic              dac_load,
  output logic              busy
);

  logic [NCH-1:0]             slot_hit;
  logic [NCH-1:0][CODE_W-1:0] stage_codes;
  logic                       xfer_start;
  logic                       xfer_done;

  dac_addr_decode #(
    .ADDR_W(ADDR_W), .NCH(NCH), .BASE_ADDR(BASE_ADDR), .STRIDE(STRIDE)
  ) u_dec (
    .addr (addr),
    .hit  (slot_hit)
  );

  dac_stage_regs #(
    .NCH(NCH), .CODE_W(CODE_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .hit      (slot_hit),
    .eng_done (xfer_done),
    .codes    (stage_codes),
    .busy_q   (busy),
    .start_q  (xfer_start),
    .rd_data  (rd_data)
  );

  dac_serial_engine #(
    .NCH(NCH), .CODE_W(CODE_W), .FRAME_W(FRAME_W), .HALF_DIV(HALF_DIV)
  ) u_eng (
    .clk   (clk),
    .rst   (rst),
    .start (xfer_start),
    .codes (stage_codes),
    .sclk  (dac_sclk),
    .din   (dac_din),
    .cs_n  (dac_cs_n),
    .load  (dac_load),
    .done  (xfer_done)
  );

endmodule

// File: rtl/dac_sync_front_chk.sv
module dac_sync_front_chk #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CODE_W = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       busy,
  input logic                       dac_cs_n,
  input logic                       dac_sclk,
  input logic                       dac_din,
  input logic                       dac_load,
  input logic [NCH-1:0][CODE_W-1:0] codes
);

  // R2 R4: no frame is ever selected while the block is idle
  assert_cs_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> dac_cs_n);

  // R6: clock and data are quiet whenever no frame is selected
  assert_sclk_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_sclk);
  assert_din_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    dac_cs_n |-> !dac_din);

  // R7: the load strobe is a single cycle, outside any frame
  assert_load_single_R7: assert property (@(posedge clk) disable iff (rst)
    dac_load |=> !dac_load);
  assert_load_deselected_R7: assert property (@(posedge clk) disable iff (rst)
    dac_load |-> (dac_cs_n && busy));
  assert_busy_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(dac_load));

  // R8: staged codes never move while an update runs
  assert_codes_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(codes));

endmodule

bind dac_sync_front dac_sync_front_chk #(.NCH(NCH), .CODE_W(CODE_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .dac_cs_n (dac_cs_n),
  .dac_sclk (dac_sclk),
  .dac_din  (dac_din),
  .dac_load (dac_load),
  .codes    (stage_codes)
);

// File: tb/dac_sync_front_bench.sv
module dac_sync_front_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] rd_data;
  logic        dac_sclk, dac_din, dac_cs_n, dac_load, busy;

  always #5 clk = ~clk;

  dac_sync_front u_dac_sync_front (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .dac_sclk(dac_sclk), .dac_din(dac_din),
    .dac_cs_n(dac_cs_n), .dac_load(dac_load), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // behavioural model state
  int          m_stg [4];
  bit          m_busy = 1'b0;
  int          m_s = -2;           // -2 idle, -1 pending start, >=0 offset
  logic [15:0] m_rd = 16'h0000;
  logic        e_cs, e_sclk, e_din, e_ld;

  int frames_seen = 0;
  int busy_cycles = 0;
  logic prev_cs = 1'b1;

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int slot_of(input logic [7:0] a);
    for (int i = 0; i < 4; i++) if (a == 8'hA0 + 8'(2 * i)) return i;
    return -1;
  endfunction

  task automatic model_edge(input logic we, input logic [7:0] a, input logic [15:0] d);
    int c;
    bit ob;
    if (rst) begin
      for (int i = 0; i < 4; i++) m_stg[i] = 0;
      m_busy = 1'b0; m_s = -2; m_rd = 16'h0000;
    end else begin
      c = slot_of(a);
      m_rd = (c >= 0) ? {m_busy, 3'b000, 12'(m_stg[c])} : 16'h0000;
      ob = m_busy;
      if (m_s >= -1) begin
        m_s++;
        if (m_s == 133) begin m_s = -2; m_busy = 1'b0; end
      end
      if (we && !ob && c >= 0) begin
        m_stg[c] = int'(d[11:0]);
        if (d[15]) begin m_busy = 1'b1; m_s = -1; end
      end
    end
    e_cs = 1'b1; e_sclk = 1'b0; e_din = 1'b0; e_ld = 1'b0;
    if (m_s >= 0 && m_s < 132) begin
      int f, r;
      logic [15:0] fr;
      f = m_s / 33; r = m_s % 33;
      if (r < 32) begin
        fr = {f[1:0], 2'b00, 12'(m_stg[f])};
        e_cs = 1'b0; e_sclk = r[0]; e_din = fr[15 - r / 2];
      end
    end else if (m_s == 132) begin
      e_ld = 1'b1;
    end
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [15:0] d);
    wr_en = we; addr = a; wr_data = d;
    @(posedge clk);
    model_edge(we, a, d);
    @(negedge clk);
    check("R6", "cs_n", 16'(dac_cs_n), 16'(e_cs));
    check("R6", "sclk", 16'(dac_sclk), 16'(e_sclk));
    check("R5", "din",  16'(dac_din),  16'(e_din));
    check("R7", "load", 16'(dac_load), 16'(e_ld));
    check("R4", "busy", 16'(busy),     16'(m_busy));
    check("R3", "rd_data", rd_data, m_rd);
    if (prev_cs && !dac_cs_n) frames_seen++;
    prev_cs = dac_cs_n;
    if (busy) busy_cycles++;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n, input logic [7:0] a);
    for (int i = 0; i < n; i++) step(1'b0, a, 16'h0000);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    rst = 1'b1;
    idle(3, 8'h00);
    rst = 1'b0;
    // R1: reset state
    check("R1", "cs_n reset", 16'(dac_cs_n), 16'h1);
    check("R1", "busy reset", 16'(busy), 16'h0);
    check("R1", "load reset", 16'(dac_load), 16'h0);
    check("R1", "rd reset", rd_data, 16'h0000);
    idle(1, 8'hA2);
    check("R1", "staged code reset", rd_data, 16'h0000);

    // R2: plain stores, no transfer
    step(1'b1, 8'hA0, 16'h0123);
    step(1'b1, 8'hA2, 16'h0ABC);
    step(1'b1, 8'hA4, 16'h7FFF);
    step(1'b1, 8'hA6, 16'h0000);
    check("R2", "no busy after stores", 16'(busy), 16'h0);
    check("R2", "no frame after stores", 16'(frames_seen), 16'h0);
    idle(1, 8'hA4);
    check("R2", "ch2 readback", rd_data, 16'h0FFF);
    idle(1, 8'hA2);
    check("R2", "ch1 readback", rd_data, 16'h0ABC);

    // R9: writes to non-channel addresses
    step(1'b1, 8'hA1, 16'h8555);
    step(1'b1, 8'hA8, 16'h8555);
    step(1'b1, 8'h9E, 16'h0555);
    idle(1, 8'hA0);
    check("R9", "ch0 untouched", rd_data, 16'h0123);
    check("R9", "no transfer", 16'(busy), 16'h0);
    idle(1, 8'hA1);
    check("R3", "odd address reads 0", rd_data, 16'h0000);

    // R4: trigger on channel 2
    frames_seen = 0; busy_cycles = 0;
    step(1'b1, 8'hA4, 16'h8777);
    check("R4", "busy after trigger", 16'(busy), 16'h1);
    idle(1, 8'hA4);
    check("R3", "busy bit in readback", rd_data, 16'h8777);
    // R8: writes during the transfer
    step(1'b1, 8'hA0, 16'h8001);
    step(1'b1, 8'hA6, 16'h0FED);
    idle(140, 8'hA0);
    check("R8", "ch0 kept during busy", rd_data, 16'h0123);
    check("R5", "four frames sent", 16'(frames_seen), 16'd4);
    check("R7", "busy length", 16'(busy_cycles), 16'd134);
    idle(1, 8'hA6);
    check("R8", "ch3 kept during busy", rd_data, 16'h0000);

    // R10: trigger with unchanged code
    frames_seen = 0; busy_cycles = 0;
    step(1'b1, 8'hA2, 16'h8ABC);
    idle(135, 8'hA2);
    check("R10", "all frames resent", 16'(frames_seen), 16'd4);
    check("R7", "busy length again", 16'(busy_cycles), 16'd134);

    // back-to-back triggers: second waits until busy falls
    step(1'b1, 8'hA6, 16'h8F0F);
    while (busy) step(1'b1, 8'hA0, 16'h8AAA);
    frames_seen = 0;
    step(1'b1, 8'hA0, 16'h8555);
    idle(136, 8'hA0);
    check("R5", "frames after back-to-back", 16'(frames_seen), 16'd4);
    check("R3", "final ch0", rd_data, 16'h0555);

    finish_run();
  end

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

endmodule